// File: doc/BRIEF.md
# Split-Half Processing Scratchpad Memory

This block is a 32 KB on-chip scratchpad placed between a memory-side transfer controller and a single processing engine. Both sides address the same 8192-word space (13-bit word address, 32-bit words). Address bit 12 divides the space into two 16 KB halves, and each half has a fixed direction of flow. The transfer controller deposits input operands into the upper half and collects results from the lower half. The engine does the reverse: it fetches operands from the upper half and stores results in the lower half.

Each side has its own clock and its own synchronous active-low reset. Each side drives a plain synchronous request port: request, write-enable, address and write data in; read data and an error pulse out. An access that goes against a side's direction is discarded and flagged. Each half is built from four 1024-word RAM banks, chosen by address bits 11:10. Every bank has one writer and one reader, and these sit on opposite clocks. No bank is ever shared by two writers.

Top module: `splitpad_mem`

## Requirements
- R1: A memory-side write (we=1) to an address with bit 12 = 1 stores the data, and a later engine-side read of that address returns it.
- R2: An engine-side write (we=1) to an address with bit 12 = 0 stores the data, and a later memory-side read of that address returns it.
- R3: Read data for a legal read appears on the requesting side's rdata on the first clock edge of that side after the request, and err stays 0 for it.
- R4: A memory-side write to the lower half (bit 12 = 0) leaves the storage unchanged and makes m_err 1 for exactly the following cycle.
- R5: A memory-side read of the upper half (bit 12 = 1) makes m_rdata zero and m_err 1 in the following cycle.
- R6: An engine-side write to the upper half leaves the storage unchanged and makes e_err 1 for the following cycle.
- R7: An engine-side read of the lower half makes e_rdata zero and e_err 1 in the following cycle.
- R8: Within a half, address bits 11:10 pick one of four independent banks, and bits 9:0 pick the word inside it. Addresses that differ only in bits 11:10 hold separate data.
- R9: In a cycle without a request, err is 0 in the next cycle and rdata keeps its previous value.
- R10: After reset, each side's rdata and err are 0.
- R11: The two sides operate at the same time on unrelated clocks without disturbing each other's accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Memory-side clock |
| rst_m_n | input | 1 | Memory-side synchronous active-low reset |
| m_req | input | 1 | Memory-side access request |
| m_we | input | 1 | Memory-side write (1) or read (0) |
| m_addr | input | 13 | Memory-side word address |
| m_wdata | input | 32 | Memory-side write data |
| m_rdata | output | 32 | Memory-side read data, one cycle after the request |
| m_err | output | 1 | Memory-side illegal-access pulse |
| clk_e | input | 1 | Engine-side clock |
| rst_e_n | input | 1 | Engine-side synchronous active-low reset |
| e_req | input | 1 | Engine-side access request |
| e_we | input | 1 | Engine-side write (1) or read (0) |
| e_addr | input | 13 | Engine-side word address |
| e_wdata | input | 32 | Engine-side write data |
| e_rdata | output | 32 | Engine-side read data, one cycle after the request |
| e_err | output | 1 | Engine-side illegal-access pulse |

## Verification
The hardest case to reach is a word written on one clock and read back on the other, while the other side is busy with its own traffic on an unrelated clock. The stimulus fills both halves completely from both sides at once, with 8 ns and 10 ns clocks. When both fills are done, it reads back across every bank boundary from both sides, again at once. After that, illegal writes are aimed at words that already hold known data. A legal read of the same word then shows whether the illegal write changed it.

// File: rtl/splitpad_pkg.sv
// Package: shared access classification for the split-half scratchpad.
// Assumes: one request per cycle per side; classification is purely combinational.
package splitpad_pkg;

    // Outcome of one side's request in the current cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/splitpad_decode.sv
// Module: splitpad_decode
// Classifies one side's request against that side's direction rights and
// splits the address into bank select and row.
// Assumes: the top address bit picks the half; WR_HALF is the half this side may write,
// and it may read only the other half.
module splitpad_decode
    import splitpad_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int SEL_W   = 2,
    parameter int ROW_W   = 10,
    parameter bit WR_HALF = 1'b1
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [SEL_W-1:0]  sel,
    output logic [ROW_W-1:0]  row
);

    localparam int HALF_BIT = ADDR_W - 1;

    logic in_own_half;

    // Purpose: compare the half bit with the writable half of this side.
    always_comb begin
        in_own_half = (addr[HALF_BIT] == WR_HALF);
    end

    // Purpose: pick the access kind from the request, direction and half.
    always_comb begin
        if (!req) begin
            kind = ACC_IDLE;
        end else if (we && in_own_half) begin
            kind = ACC_WRITE;
        end else if (!we && !in_own_half) begin
            kind = ACC_READ;
        end else begin
            kind = ACC_BAD;
        end
    end

    // Purpose: slice the bank select and the row out of the word address.
    always_comb begin
        sel = addr[ROW_W +: SEL_W];
        row = addr[ROW_W-1:0];
    end

endmodule

// File: rtl/splitpad_bank.sv
// Module: splitpad_bank
// One RAM bank with a write port and a registered read port on separate clocks.
// Assumes: its two clocks may be unrelated; the users never read and write the
// same row in overlapping windows; contents are not reset.
module splitpad_bank #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 10
) (
    input  logic              wclk,
    input  logic              wen,
    input  logic [ROW_W-1:0]  wrow,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              ren,
    input  logic [ROW_W-1:0]  rrow,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store a word on the writer's clock.
    always_ff @(posedge wclk) begin
        if (wen) begin
            mem[wrow] <= wdata;
        end
    end

    // Purpose: capture a word on the reader's clock and hold it until the next read.
    always_ff @(posedge rclk) begin
        if (ren) begin
            rdata <= mem[rrow];
        end
    end

endmodule

// File: rtl/splitpad_port.sv
// Module: splitpad_port
// One side's request port: decodes the request, raises per-bank write and read
// strobes, registers the error pulse and picks the registered bank output.
// Assumes: the banks this side reads register their data on this side's clock;
// writes go straight to the banks of this side's writable half.
module splitpad_port
    import splitpad_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 2,
    parameter bit WR_HALF = 1'b1,
    localparam int ROW_W  = ADDR_W - 1 - SEL_W,
    localparam int NB     = 1 << SEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       err,
    output logic [NB-1:0]              bank_wen,
    output logic [NB-1:0]              bank_ren,
    output logic [ROW_W-1:0]           bank_row,
    output logic [DATA_W-1:0]          bank_wdata,
    input  logic [NB-1:0][DATA_W-1:0]  bank_q
);

    localparam int HALF_BIT = ADDR_W - 1;

    acc_kind_e        kind;
    logic [SEL_W-1:0] sel;
    logic [ROW_W-1:0] row;
    logic             req_live;
    logic             err_q;
    logic             ok_q;
    logic [SEL_W-1:0] sel_q;

    // Purpose: ignore requests while this side is held in reset.
    always_comb begin
        req_live = req && rst_n;
    end

    splitpad_decode #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W),
        .ROW_W  (ROW_W),
        .WR_HALF(WR_HALF)
    ) decode_i (
        .req (req_live),
        .we  (we),
        .addr(addr),
        .kind(kind),
        .sel (sel),
        .row (row)
    );

    // Purpose: raise the write or read strobe of the addressed bank only.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_wen[b] = (kind == ACC_WRITE) && (sel == SEL_W'(b));
            bank_ren[b] = (kind == ACC_READ)  && (sel == SEL_W'(b));
        end
        bank_row   = row;
        bank_wdata = wdata;
    end

    // Purpose: register the error pulse and the read-return selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            ok_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            err_q <= (kind == ACC_BAD);
            if (kind == ACC_READ) begin
                ok_q  <= 1'b1;
                sel_q <= sel;
            end else if ((kind == ACC_BAD) && !we) begin
                ok_q  <= 1'b0;
            end
        end
    end

    // Purpose: return the selected bank word, or zero after a refused read.
    always_comb begin
        rdata = ok_q ? bank_q[sel_q] : '0;
        err   = err_q;
    end

    // R4 / R6: a write into the read-only half is flagged on the next cycle.
    assert_bad_write_flag_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (addr[HALF_BIT] != WR_HALF)) |=> err);

    // R5 / R7: a read of the write-only half returns zero with the flag.
    assert_bad_read_zero_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && (addr[HALF_BIT] == WR_HALF)) |=> (err && (rdata == '0)));

    // R3: a legal read never raises the flag.
    assert_legal_read_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && (addr[HALF_BIT] != WR_HALF)) |=> !err);

    // R9: an idle cycle clears the flag and keeps the returned data.
    assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !err);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(rdata));

endmodule

// File: rtl/splitpad_mem.sv
// Module: splitpad_mem (top)
// 32 KB split-half scratchpad. The memory side writes the upper half and reads
// the lower half; the engine side writes the lower half and reads the upper half.
// Each half holds NB banks; each bank's writer and reader sit on opposite clocks.
// Assumes: unrelated clocks; software-level ordering keeps a word from being
// read on one side while the other side is still writing it.
module splitpad_mem #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 2
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_err,
    input  logic              clk_e,
    input  logic              rst_e_n,
    input  logic              e_req,
    input  logic              e_we,
    input  logic [ADDR_W-1:0] e_addr,
    input  logic [DATA_W-1:0] e_wdata,
    output logic [DATA_W-1:0] e_rdata,
    output logic              e_err
);

    localparam int ROW_W = ADDR_W - 1 - SEL_W;
    localparam int NB    = 1 << SEL_W;

    logic [NB-1:0]             m_wen, m_ren, e_wen, e_ren;
    logic [ROW_W-1:0]          m_row, e_row;
    logic [DATA_W-1:0]         m_bwdata, e_bwdata;
    logic [NB-1:0][DATA_W-1:0] m_bank_q, e_bank_q;

    // Memory side: may write the upper half, reads the lower half.
    splitpad_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .WR_HALF(1'b1)
    ) mport_i (
        .clk       (clk_m),
        .rst_n     (rst_m_n),
        .req       (m_req),
        .we        (m_we),
        .addr      (m_addr),
        .wdata     (m_wdata),
        .rdata     (m_rdata),
        .err       (m_err),
        .bank_wen  (m_wen),
        .bank_ren  (m_ren),
        .bank_row  (m_row),
        .bank_wdata(m_bwdata),
        .bank_q    (m_bank_q)
    );

    // Engine side: may write the lower half, reads the upper half.
    splitpad_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .WR_HALF(1'b0)
    ) eport_i (
        .clk       (clk_e),
        .rst_n     (rst_e_n),
        .req       (e_req),
        .we        (e_we),
        .addr      (e_addr),
        .wdata     (e_wdata),
        .rdata     (e_rdata),
        .err       (e_err),
        .bank_wen  (e_wen),
        .bank_ren  (e_ren),
        .bank_row  (e_row),
        .bank_wdata(e_bwdata),
        .bank_q    (e_bank_q)
    );

    // Purpose: build the upper-half banks (memory writes, engine reads) and the
    // lower-half banks (engine writes, memory reads).
    for (genvar b = 0; b < NB; b++) begin : g_bank
        splitpad_bank #(
            .DATA_W(DATA_W),
            .ROW_W (ROW_W)
        ) upper_i (
            .wclk (clk_m),
            .wen  (m_wen[b]),
            .wrow (m_row),
            .wdata(m_bwdata),
            .rclk (clk_e),
            .ren  (e_ren[b]),
            .rrow (e_row),
            .rdata(e_bank_q[b])
        );

        splitpad_bank #(
            .DATA_W(DATA_W),
            .ROW_W (ROW_W)
        ) lower_i (
            .wclk (clk_e),
            .wen  (e_wen[b]),
            .wrow (e_row),
            .wdata(e_bwdata),
            .rclk (clk_m),
            .ren  (m_ren[b]),
            .rrow (m_row),
            .rdata(m_bank_q[b])
        );
    end

    // R8: at most one bank strobed per side per cycle.
    assert_one_bank_m_R8: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        $onehot0({m_wen, m_ren}));

    assert_one_bank_e_R8: assert property (@(posedge clk_e) disable iff (!rst_e_n)
        $onehot0({e_wen, e_ren}));

endmodule

// File: tb/splitpad_mem_tb.sv
// Bench: behavioural word model of the scratchpad, compared on every cycle of each side.
module splitpad_mem_tb_top;

    logic        clk_m = 1'b0;
    logic        clk_e = 1'b0;
    logic        rst_m_n = 1'b0;
    logic        rst_e_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0;
    logic [12:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        m_err;
    logic        e_req = 1'b0, e_we = 1'b0;
    logic [12:0] e_addr = '0;
    logic [31:0] e_wdata = '0;
    logic [31:0] e_rdata;
    logic        e_err;

    int unsigned n_cmp  = 0;
    int unsigned n_fail = 0;

    logic [31:0] mdl [int];
    logic [31:0] exp_m_rd = '0;
    logic [31:0] exp_e_rd = '0;

    always #4 clk_m = ~clk_m;   // memory side, 125 MHz
    always #5 clk_e = ~clk_e;   // engine side, 100 MHz

    splitpad_mem dut_i (
        .clk_m(clk_m), .rst_m_n(rst_m_n),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_err(m_err),
        .clk_e(clk_e), .rst_e_n(rst_e_n),
        .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata),
        .e_rdata(e_rdata), .e_err(e_err)
    );

    function automatic logic [31:0] pat_up(int i);
        return 32'hA500_0000 ^ (i * 32'h0000_9E37);
    endfunction

    function automatic logic [31:0] pat_lo(int i);
        return 32'h5A00_0000 + (i * 32'h0101_0003);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference rule: write own half, read the other half, otherwise drop and flag.
    task automatic predict(bit wr_half, bit req, bit we, logic [12:0] addr,
                           logic [31:0] data, inout logic [31:0] rd, output bit er);
        er = 1'b0;
        if (req) begin
            if (we && (addr[12] == wr_half)) mdl[int'(addr)] = data;
            else if (!we && (addr[12] != wr_half)) rd = mdl.exists(int'(addr)) ? mdl[int'(addr)] : 32'h0;
            else if (we) er = 1'b1;
            else begin rd = 32'h0; er = 1'b1; end
        end
    endtask

    task automatic m_op(string tag, bit req, bit we, logic [12:0] addr, logic [31:0] data);
        bit er;
        @(negedge clk_m);
        m_req = req; m_we = we; m_addr = addr; m_wdata = data;
        predict(1'b1, req, we, addr, data, exp_m_rd, er);
        @(posedge clk_m);
        @(negedge clk_m);
        m_req = 1'b0;
        chk(tag, "m_rdata", m_rdata, exp_m_rd);
        chk(tag, "m_err", {31'b0, m_err}, {31'b0, er});
    endtask

    task automatic e_op(string tag, bit req, bit we, logic [12:0] addr, logic [31:0] data);
        bit er;
        @(negedge clk_e);
        e_req = req; e_we = we; e_addr = addr; e_wdata = data;
        predict(1'b0, req, we, addr, data, exp_e_rd, er);
        @(posedge clk_e);
        @(negedge clk_e);
        e_req = 1'b0;
        chk(tag, "e_rdata", e_rdata, exp_e_rd);
        chk(tag, "e_err", {31'b0, e_err}, {31'b0, er});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk_e);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk_e);
        @(negedge clk_m); rst_m_n = 1'b1;
        @(negedge clk_e); rst_e_n = 1'b1;

        // R10: reset state on both sides.
        @(negedge clk_m);
        chk("R10", "m_rdata", m_rdata, 32'h0);
        chk("R10", "m_err", {31'b0, m_err}, 32'h0);
        @(negedge clk_e);
        chk("R10", "e_rdata", e_rdata, 32'h0);
        chk("R10", "e_err", {31'b0, e_err}, 32'h0);

        // R1 / R2 / R11: fill both halves at once from both clocks.
        fork
            for (int i = 0; i < 4096; i++) m_op("R1_R11", 1'b1, 1'b1, 13'h1000 | 13'(i), pat_up(i));
            for (int i = 0; i < 4096; i++) e_op("R2_R11", 1'b1, 1'b1, 13'(i), pat_lo(i));
        join

        // R3 / R2 / R1 / R11: concurrent read-back across both halves.
        fork
            for (int i = 0; i < 4096; i += 37) m_op("R2_R3", 1'b1, 1'b0, 13'(i), 32'h0);
            for (int i = 5; i < 4096; i += 41) e_op("R1_R3", 1'b1, 1'b0, 13'h1000 | 13'(i), 32'h0);
        join

        // R8: same row in each bank, words differ only in bits 11:10.
        for (int b = 0; b < 4; b++) begin
            m_op("R8", 1'b1, 1'b0, 13'((b << 10) | 7), 32'h0);
            e_op("R8", 1'b1, 1'b0, 13'h1000 | 13'((b << 10) | 1023), 32'h0);
        end

        // R4: memory write into lower half is dropped and flagged.
        m_op("R4", 1'b1, 1'b1, 13'h0123, 32'hDEAD_BEEF);
        m_op("R4", 1'b1, 1'b0, 13'h0123, 32'h0);
        // R9: idle after a legal read holds the data.
        m_op("R9", 1'b0, 1'b0, 13'h0, 32'h0);
        m_op("R9", 1'b0, 1'b1, 13'h0123, 32'h1234_5678);
        // R5: memory read of the upper half gives zero and flags.
        m_op("R5", 1'b1, 1'b0, 13'h1123, 32'h0);
        m_op("R9", 1'b0, 1'b0, 13'h0, 32'h0);
        m_op("R3", 1'b1, 1'b0, 13'h0FFF, 32'h0);
        m_op("R5", 1'b1, 1'b0, 13'h1FFF, 32'h0);
        m_op("R4", 1'b1, 1'b1, 13'h0FFF, 32'h0BAD_0BAD);
        m_op("R4", 1'b1, 1'b0, 13'h0FFF, 32'h0);

        // R6: engine write into upper half is dropped and flagged.
        e_op("R6", 1'b1, 1'b1, 13'h1456, 32'hFACE_CAFE);
        e_op("R6", 1'b1, 1'b0, 13'h1456, 32'h0);
        e_op("R9", 1'b0, 1'b0, 13'h0, 32'h0);
        // R7: engine read of lower half gives zero and flags.
        e_op("R7", 1'b1, 1'b0, 13'h0456, 32'h0);
        e_op("R9", 1'b0, 1'b0, 13'h0, 32'h0);
        e_op("R3", 1'b1, 1'b0, 13'h1000, 32'h0);
        e_op("R7", 1'b1, 1'b0, 13'h0000, 32'h0);
        e_op("R6", 1'b1, 1'b1, 13'h1000, 32'h0);
        e_op("R1", 1'b1, 1'b0, 13'h1000, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule